// File: doc/BRIEF.md
# Instruction Fetch Window Guard

This block sits beside a CPU and watches its instruction-fetch port. Software describes a forbidden code region with a lower and an upper address held in two registers. It then arms the guard by writing a control register. From then on, any valid fetch whose address falls inside the region raises a trap request to the CPU. The request stays raised until reset.

Once the guard is armed, the region is frozen. Later writes to either bound are dropped, and the armed state cannot be withdrawn by software. This prevents code that runs after arming from moving or disabling the guard. Only fetches flagged valid are compared; data traffic never reaches this block.

Register offsets on the small write/read port are as follows. Offset 0 holds the lower bound and offset 1 the upper bound, both zero-extended to the port width on read. Offset 2 is the arm control, where bit 0 is the armed flag. Offset 3 reads as zero.

Top module: `fetch_window_guard`

## Requirements
- R1: After reset, both bounds read 0, the armed flag (offset 2, bit 0) reads 0 and `trap_req` is 0.
- R2: While unarmed, a write to offset 0 or 1 replaces that bound, and the new value reads back from the following cycle on.
- R3: A write to offset 2 with bit 0 set arms the guard, and offset 2 then reads 1. A write to offset 2 with bit 0 clear never disarms it; only reset does.
- R4: While armed, writes to offset 0 and offset 1 are ignored, and both bounds read back unchanged.
- R5: When armed, a cycle with `fetch_valid` high and lower <= `fetch_addr` <= upper raises `trap_req` on the next clock edge. Both bounds count as inside the region.
- R6: `trap_req` does not rise on a fetch outside the region, on a cycle with `fetch_valid` low, or while the guard is unarmed.
- R7: Once raised, `trap_req` stays 1 until reset, whatever fetches follow.
- R8: When the lower bound exceeds the upper bound, the region is empty and no fetch address raises a trap.
- R9: Detecting a violation leaves both bound registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, combinational from `reg_addr` |
| fetch_valid | input | 1 | Qualifies `fetch_addr` as a real instruction fetch |
| fetch_addr | input | W | Instruction fetch address |
| trap_req | output | 1 | Sticky trap request to the CPU |

## Verification
The assertions assume that `reg_addr`, `reg_we`, `fetch_valid` and `fetch_addr` are settled at each rising edge. They also assume that software writes only offsets 0 to 2. The bench drives every input on the falling edge and returns `reg_we` and `fetch_valid` to zero afterwards, so no strobe spans two edges by accident. Because the trap is sticky, the bench resets before each single-address probe. This lets one sweep cover all 256 addresses of the 8-bit configuration for each region, with no trap left over from an earlier probe.

// File: rtl/fetch_window_guard.sv
module fetch_window_guard #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         fetch_valid,
  input  logic [W-1:0] fetch_addr,
  output logic         trap_req
);
  localparam logic [1:0] OFS_LO  = 2'd0;
  localparam logic [1:0] OFS_HI  = 2'd1;
  localparam logic [1:0] OFS_ARM = 2'd2;

  logic [W-1:0] first_q, last_q;
  logic         armed_q, trap_q;
  logic         hit;

  assign hit = armed_q && fetch_valid && (fetch_addr >= first_q) && (fetch_addr <= last_q);
  assign trap_req = trap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      armed_q <= 1'b0;
      trap_q  <= 1'b0;
    end else begin
      trap_q <= trap_q | hit;
      if (reg_we) begin
        if (reg_addr == OFS_LO && !armed_q) first_q <= reg_wdata;
        if (reg_addr == OFS_HI && !armed_q) last_q  <= reg_wdata;
        if (reg_addr == OFS_ARM && reg_wdata[0]) armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_LO:  reg_rdata = first_q;
      OFS_HI:  reg_rdata = last_q;
      OFS_ARM: reg_rdata = {{(W-1){1'b0}}, armed_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

module fetch_window_guard_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fetch_valid,
  input logic [W-1:0] fetch_addr,
  input logic         trap_req,
  input logic         armed,
  input logic [W-1:0] first,
  input logic [W-1:0] last
);
  // R7
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> trap_req);

  // R5
  hit_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fetch_valid && fetch_addr >= first && fetch_addr <= last) |=> trap_req);

  // R6
  no_spurious_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !(armed && fetch_valid && fetch_addr >= first && fetch_addr <= last))
      |=> !trap_req);

  // R4
  window_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(first) && $stable(last)));

  // R3
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R8
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && first > last) |=> !trap_req);
endmodule

bind fetch_window_guard fetch_window_guard_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
  .trap_req(trap_req), .armed(armed_q), .first(first_q), .last(last_q)
);

// File: tb/fetch_window_guard_tb.sv
module fetch_window_guard_tb;
  localparam int W = 8;
  localparam int HALF = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [1:0]   reg_addr = 2'd0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         fetch_valid = 1'b0;
  logic [W-1:0] fetch_addr = '0;
  logic         trap_req;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  fetch_window_guard #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .trap_req(trap_req)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_we = 1'b0;
    fetch_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = a;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input int exp);
    reg_addr = a;
    #1;
    check(req, int'(reg_rdata), exp);
  endtask

  task automatic fetch(input logic v, input logic [W-1:0] a);
    @(negedge clk);
    fetch_valid = v;
    fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    #1;
  endtask

  task automatic sweep(input string req, input int lo, input int hi);
    for (int a = 0; a < 256; a++) begin
      do_reset();
      wr(2'd0, W'(lo));
      wr(2'd1, W'(hi));
      wr(2'd2, 8'h01);
      fetch(1'b1, W'(a));
      check(req, int'(trap_req), (lo <= a && a <= hi) ? 1 : 0);
    end
  endtask

  initial begin
    do_reset();
    // R1 reset state
    rd_check("R1", 2'd0, 0);
    rd_check("R1", 2'd1, 0);
    rd_check("R1", 2'd2, 0);
    check("R1", int'(trap_req), 0);

    // R2 programming while unarmed
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h20);
    rd_check("R2", 2'd0, 'h10);
    rd_check("R2", 2'd1, 'h20);
    wr(2'd0, 8'h30);
    rd_check("R2", 2'd0, 'h30);

    // R6 unarmed: no address traps
    for (int a = 0; a < 256; a++) begin
      fetch(1'b1, W'(a));
      check("R6", int'(trap_req), 0);
    end

    // R3 arm with bit 0 clear does nothing, then arm, then clear attempt
    wr(2'd2, 8'hFE);
    rd_check("R3", 2'd2, 0);
    wr(2'd2, 8'h01);
    rd_check("R3", 2'd2, 1);
    wr(2'd2, 8'h00);
    rd_check("R3", 2'd2, 1);

    // R4 window locked once armed
    wr(2'd0, 8'hDE);
    wr(2'd1, 8'hCA);
    rd_check("R4", 2'd0, 'h30);
    rd_check("R4", 2'd1, 'h20);

    // R6 valid low never traps even inside window
    for (int a = 0; a < 256; a++) begin
      do_reset();
      wr(2'd0, 8'h00);
      wr(2'd1, 8'hFF);
      wr(2'd2, 8'h01);
      fetch(1'b0, W'(a));
      check("R6", int'(trap_req), 0);
    end

    // R5 inclusive window sweeps
    sweep("R5", 'h40, 'h80);
    sweep("R5", 'h13, 'h13);
    sweep("R5", 'h00, 'hFF);
    // R8 inverted window is empty
    sweep("R8", 'h90, 'h20);

    // R7 sticky and R9 window unchanged after violation
    do_reset();
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h01);
    fetch(1'b1, 8'h17);
    check("R5", int'(trap_req), 1);
    for (int a = 0; a < 16; a++) begin
      fetch(1'b1, W'(8'hA0 + a));
      check("R7", int'(trap_req), 1);
    end
    repeat (20) @(negedge clk);
    #1;
    check("R7", int'(trap_req), 1);
    rd_check("R9", 2'd0, 'h10);
    rd_check("R9", 2'd1, 'h20);
    do_reset();
    #1;
    check("R7", int'(trap_req), 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(2 * HALF * 150000);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule